// File: doc/BRIEF.md
# Write-Invalidate Four-State Coherence Cluster

This block keeps the private caches of several cores coherent over one shared snooping bus. Each core owns a small direct-mapped cache of one-word lines, and every line carries one of four coherence states: Invalid (0), Shared (1), Exclusive (2) and Modified (3). A per-core controller takes load and store requests, serves hits locally, and raises bus transactions for misses, ownership upgrades and dirty evictions. Every other controller watches each transaction, reports whether it holds the line, supplies the word when it holds it dirty, and downgrades or drops its copy.

A round-robin arbiter lets one transaction onto the bus per cycle, so all cores see the same order of transactions. A memory stub answers fills and absorbs writebacks and dirty supplies. The whole transaction, including the snoop responses, settles in its grant cycle. The bus is brought out on ports so that its traffic can be observed.

A request is held on `req_valid` until `req_done` pulses; the word of a load is on `req_rdata` from that cycle on. Addresses are line addresses. The line index is the low `log2(NLINE)` bits and the tag is the rest.

Top module: `mesi_coherence_cluster`

## Requirements
- R1: After reset no `req_done` is high, `bus_valid` is low and every line is Invalid, so the first access to any address misses. Memory word `a` starts at (37*a + 11) mod 2^DATA_W.
- R2: A read miss that no other cache holds issues one transaction with `bus_cmd`=0 (read), `bus_shared` low and the memory word on `bus_data`. The line is filled as Exclusive.
- R3: A read miss to a line that another cache holds sees `bus_shared` high and is filled as Shared.
- R4: A store to an Exclusive or Modified line makes no bus transaction and leaves the line Modified.
- R5: An Exclusive line that snoops a read of its address becomes Shared, so a later store to it must upgrade.
- R6: A store to a Shared line first issues `bus_cmd`=2 (upgrade), with `bus_shared` high when any other cache holds the line. It then completes in the grant cycle and the line becomes Modified.
- R7: A Modified holder that snoops a read or read-for-ownership raises `bus_flush`, drives its word as `bus_data` and updates memory; at most one cache flushes at a time. After a snooped read it holds the line Shared.
- R8: A cache that snoops a read-for-ownership or an upgrade for a line it holds marks that line Invalid.
- R9: A store miss issues `bus_cmd`=1 (read-for-ownership) and leaves the line Modified with the stored word.
- R10: A miss whose slot holds a different Modified line first issues `bus_cmd`=3 (writeback) with the victim address and word, with `bus_shared` and `bus_flush` low, then the fill.
- R11: Load and store hits make no bus transaction, and every request ends with exactly one single-cycle `req_done` pulse.
- R12: At most one transaction is on the bus per cycle, and under round-robin grant, simultaneous requests from all cores all complete.
- R13: Stores are never broadcast as data. Invalidation alone makes every load return the last value stored to its address by any core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-core request held until done |
| req_write | input | NCORE | Per-core store (1) or load (0) |
| req_addr | input | NCORE*ADDR_W | Per-core line address |
| req_wdata | input | NCORE*DATA_W | Per-core store word |
| req_done | output | NCORE | Per-core completion pulse |
| req_rdata | output | NCORE*DATA_W | Per-core load word |
| bus_valid | output | 1 | A transaction is on the bus |
| bus_src | output | $clog2(NCORE) | Index of the granted core |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction line address |
| bus_data | output | DATA_W | Fill word, or written word for writeback |
| bus_shared | output | 1 | Another cache holds the line |
| bus_flush | output | 1 | A Modified holder supplies the word |

## Verification
The bench walks a store through every holder pattern. It covers a store to an Exclusive line, which a design missing the silent upgrade would put on the bus. A snooped read of an Exclusive line is followed by a store that must now upgrade; a design that kept the line Exclusive would stay silent and leave the other reader stale. A read-for-ownership of a Modified line must take the owner's word and not memory's, and the same slot is then reused so that a dirty victim must be written back before its fill. A long pseudo-random sweep of loads and stores across three cores, with aliasing addresses, compares every bus transaction and every loaded word with a four-state model kept in the bench.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;

  // State a held line takes after another core's transaction to it
  function automatic line_st_e snoop_next(line_st_e cur, bus_cmd_e cmd);
    if (cur == ST_I) return ST_I;
    if (cmd == BC_WB) return cur;
    if (cmd == BC_RD) return ST_S;
    return ST_I;
  endfunction

  // State a line is filled with after a read or ownership miss
  function automatic line_st_e fill_state(logic for_store, logic others_hold);
    if (for_store) return ST_M;
    return others_hold ? ST_S : ST_E;
  endfunction

  // Power-on content of memory word a
  function automatic logic [31:0] mem_seed(logic [31:0] a);
    return a * 32'd37 + 32'd11;
  endfunction

endpackage

// File: rtl/mesi_rr_arbiter.sv
module mesi_rr_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last_q;
  int            pick;

  function automatic int rr_pick(logic [N-1:0] r, int last);
    for (int off = 1; off <= N; off++) begin
      if (r[(last + off) % N]) return (last + off) % N;
    end
    return -1;
  endfunction

  always_comb begin
    pick = rr_pick(req, int'(last_q));
    for (int i = 0; i < N; i++) gnt[i] = (pick == i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= PW'(N - 1);
    else if (|gnt) last_q <= PW'(pick);
  end

endmodule

// File: rtl/mesi_mem_stub.sv
module mesi_mem_stub
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(mem_seed(32'(i)));
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int CORE_ID = 0,
  parameter int NCORE   = 3,
  parameter int NLINE   = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_done,
  output logic [DATA_W-1:0]        req_rdata,
  output logic                     bus_req,
  output bus_cmd_e                 bus_req_cmd,
  output logic [ADDR_W-1:0]        bus_req_addr,
  output logic [DATA_W-1:0]        bus_req_data,
  input  logic                     bus_gnt,
  input  logic                     bus_valid,
  input  logic [$clog2(NCORE)-1:0] bus_src,
  input  bus_cmd_e                 bus_cmd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_data,
  input  logic                     bus_shared,
  output logic                     snp_hit,
  output logic                     snp_flush,
  output logic [DATA_W-1:0]        snp_data
);
  localparam int IDX_W = $clog2(NLINE);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SRC_W = $clog2(NCORE);

  typedef enum logic [1:0] {CS_IDLE, CS_WORK, CS_ACK} ctl_e;

  ctl_e              cs_q;
  line_st_e          st_q [NLINE];
  logic [TAG_W-1:0]  tg_q [NLINE];
  logic [DATA_W-1:0] dt_q [NLINE];
  logic [ADDR_W-1:0] r_addr;
  logic              r_wr;
  logic [DATA_W-1:0] r_wd;

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  // Own request view
  logic [IDX_W-1:0] cur_idx;
  logic [TAG_W-1:0] cur_tag;
  line_st_e         cur_st;
  logic             cur_match, line_hit, need_wb, need_fill, need_upg, local_ok;

  assign cur_idx   = idx_of(r_addr);
  assign cur_tag   = tag_of(r_addr);
  assign cur_st    = st_q[cur_idx];
  assign cur_match = (tg_q[cur_idx] == cur_tag);
  assign line_hit  = (cur_st != ST_I) && cur_match;
  assign need_wb   = (cur_st == ST_M) && !cur_match;
  assign need_fill = !line_hit && !need_wb;
  assign need_upg  = line_hit && r_wr && (cur_st == ST_S);
  assign local_ok  = line_hit && !need_upg;

  // Snoop view of other cores' transactions
  logic [IDX_W-1:0] snp_idx;
  logic             snp_other, snp_line_hit, local_block;

  assign snp_idx      = idx_of(bus_addr);
  assign snp_other    = bus_valid && (bus_src != SRC_W'(CORE_ID));
  assign snp_line_hit = (st_q[snp_idx] != ST_I) && (tg_q[snp_idx] == tag_of(bus_addr));
  assign snp_hit      = snp_other && (bus_cmd != BC_WB) && snp_line_hit;
  assign snp_flush    = snp_hit && (st_q[snp_idx] == ST_M);
  assign snp_data     = dt_q[snp_idx];
  assign local_block  = snp_other && (snp_idx == cur_idx);

  // Named events
  logic local_go, fill_go, wb_go;

  assign local_go = (cs_q == CS_WORK) && local_ok && !local_block;
  assign bus_req  = (cs_q == CS_WORK) && !local_ok;
  assign fill_go  = bus_gnt && (bus_req_cmd != BC_WB);
  assign wb_go    = bus_gnt && (bus_req_cmd == BC_WB);

  always_comb begin
    if (need_wb) begin
      bus_req_cmd  = BC_WB;
      bus_req_addr = {tg_q[cur_idx], cur_idx};
      bus_req_data = dt_q[cur_idx];
    end else begin
      if (need_fill) bus_req_cmd = r_wr ? BC_RDX : BC_RD;
      else           bus_req_cmd = BC_UPG;
      bus_req_addr = r_addr;
      bus_req_data = r_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= CS_IDLE;
      req_done  <= 1'b0;
      req_rdata <= '0;
      r_addr    <= '0;
      r_wr      <= 1'b0;
      r_wd      <= '0;
      for (int i = 0; i < NLINE; i++) begin
        st_q[i] <= ST_I;
        tg_q[i] <= '0;
        dt_q[i] <= '0;
      end
    end else begin
      req_done <= 1'b0;
      case (cs_q)
        CS_IDLE: begin
          if (req_valid) begin
            r_addr <= req_addr;
            r_wr   <= req_write;
            r_wd   <= req_wdata;
            cs_q   <= CS_WORK;
          end
        end
        CS_WORK: begin
          if (local_go) begin
            if (r_wr) begin
              dt_q[cur_idx] <= r_wd;
              st_q[cur_idx] <= ST_M;
            end else begin
              req_rdata <= dt_q[cur_idx];
            end
            req_done <= 1'b1;
            cs_q     <= CS_ACK;
          end else if (fill_go) begin
            case (bus_req_cmd)
              BC_RD: begin
                st_q[cur_idx] <= fill_state(1'b0, bus_shared);
                tg_q[cur_idx] <= cur_tag;
                dt_q[cur_idx] <= bus_data;
                req_rdata     <= bus_data;
              end
              BC_RDX: begin
                st_q[cur_idx] <= fill_state(1'b1, bus_shared);
                tg_q[cur_idx] <= cur_tag;
                dt_q[cur_idx] <= r_wd;
              end
              default: begin
                st_q[cur_idx] <= ST_M;
                dt_q[cur_idx] <= r_wd;
              end
            endcase
            req_done <= 1'b1;
            cs_q     <= CS_ACK;
          end else if (wb_go) begin
            st_q[cur_idx] <= ST_I;
          end
        end
        default: begin
          if (!req_valid) cs_q <= CS_IDLE;
        end
      endcase
      if (snp_hit) st_q[snp_idx] <= snoop_next(st_q[snp_idx], bus_cmd);
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  assert_read_shares_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && bus_cmd == BC_RD) |=> (st_q[$past(snp_idx)] == ST_S));

  assert_own_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && bus_cmd != BC_RD) |=> (st_q[$past(snp_idx)] == ST_I));

  assert_grant_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req_cmd != BC_WB) |=> req_done);

endmodule

// File: rtl/mesi_coherence_cluster.sv
module mesi_coherence_cluster
  import mesi_pkg::*;
#(
  parameter int NCORE  = 3,
  parameter int NLINE  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORE-1:0]         req_valid,
  input  logic [NCORE-1:0]         req_write,
  input  logic [NCORE*ADDR_W-1:0]  req_addr,
  input  logic [NCORE*DATA_W-1:0]  req_wdata,
  output logic [NCORE-1:0]         req_done,
  output logic [NCORE*DATA_W-1:0]  req_rdata,
  output logic                     bus_valid,
  output logic [$clog2(NCORE)-1:0] bus_src,
  output logic [1:0]               bus_cmd,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [DATA_W-1:0]        bus_data,
  output logic                     bus_shared,
  output logic                     bus_flush
);
  localparam int SRC_W = $clog2(NCORE);

  logic [NCORE-1:0]  breq, gnt, shr_vec, fl_vec;
  bus_cmd_e          bcmd  [NCORE];
  logic [ADDR_W-1:0] baddr [NCORE];
  logic [DATA_W-1:0] bdata [NCORE];
  logic [DATA_W-1:0] sdata [NCORE];

  bus_cmd_e          cmd_i;
  logic [DATA_W-1:0] wd_sel, fl_data, mem_rd;
  logic              mem_we;

  mesi_rr_arbiter #(.N(NCORE)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (breq),
    .gnt  (gnt)
  );

  always_comb begin
    bus_src  = '0;
    cmd_i    = BC_RD;
    bus_addr = '0;
    wd_sel   = '0;
    fl_data  = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (gnt[i]) begin
        bus_src  = SRC_W'(i);
        cmd_i    = bcmd[i];
        bus_addr = baddr[i];
        wd_sel   = bdata[i];
      end
      if (fl_vec[i]) fl_data = fl_data | sdata[i];
    end
  end

  assign bus_valid  = |gnt;
  assign bus_cmd    = cmd_i;
  assign bus_shared = |shr_vec;
  assign bus_flush  = |fl_vec;
  assign bus_data   = (cmd_i == BC_WB) ? wd_sel : (bus_flush ? fl_data : mem_rd);
  assign mem_we     = bus_valid && ((cmd_i == BC_WB) || bus_flush);

  mesi_mem_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(bus_addr),
    .rd_data(mem_rd),
    .wr_en  (mem_we),
    .wr_addr(bus_addr),
    .wr_data(bus_data)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    mesi_line_ctrl #(
      .CORE_ID(g),
      .NCORE  (NCORE),
      .NLINE  (NLINE),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid[g]),
      .req_write   (req_write[g]),
      .req_addr    (req_addr[g*ADDR_W +: ADDR_W]),
      .req_wdata   (req_wdata[g*DATA_W +: DATA_W]),
      .req_done    (req_done[g]),
      .req_rdata   (req_rdata[g*DATA_W +: DATA_W]),
      .bus_req     (breq[g]),
      .bus_req_cmd (bcmd[g]),
      .bus_req_addr(baddr[g]),
      .bus_req_data(bdata[g]),
      .bus_gnt     (gnt[g]),
      .bus_valid   (bus_valid),
      .bus_src     (bus_src),
      .bus_cmd     (cmd_i),
      .bus_addr    (bus_addr),
      .bus_data    (bus_data),
      .bus_shared  (bus_shared),
      .snp_hit     (shr_vec[g]),
      .snp_flush   (fl_vec[g]),
      .snp_data    (sdata[g])
    );
  end

  assert_one_txn_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_one_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fl_vec) <= 1);

  assert_wb_unshared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && cmd_i == BC_WB) |-> (!bus_shared && !bus_flush));

endmodule

// File: tb/tb_mesi_coherence_cluster.sv
`timescale 1ns/1ps
module tb_mesi_coherence_cluster;
  localparam int NC = 3;
  localparam int NL = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [NC-1:0]     req_write = '0;
  logic [NC*AW-1:0]  req_addr = '0;
  logic [NC*DW-1:0]  req_wdata = '0;
  logic [NC-1:0]     req_done;
  logic [NC*DW-1:0]  req_rdata;
  logic              bus_valid;
  logic [1:0]        bus_src;
  logic [1:0]        bus_cmd;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_data;
  logic              bus_shared, bus_flush;

  always #2 clk = ~clk;

  mesi_coherence_cluster #(.NCORE(NC), .NLINE(NL), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .req_rdata(req_rdata), .bus_valid(bus_valid), .bus_src(bus_src),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_shared(bus_shared), .bus_flush(bus_flush)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Model: per core per slot state (0 I,1 S,2 E,3 M), tag, word; memory; last stored value
  int mst [NC][NL];
  int mtg [NC][NL];
  int mdt [NC][NL];
  int mem [NA];
  int mval [NA];

  int exp_n;
  int exp_pk [8];
  int exp_rd;

  int log_n = 0;
  int log_pk [8];

  function automatic int pack(int cmd, int sh, int fl, int a, int d);
    return (cmd << 14) | (sh << 13) | (fl << 12) | (a << 8) | ((cmd == 2) ? 0 : (d & 255));
  endfunction

  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      if (log_n < 8)
        log_pk[log_n] = pack(int'(bus_cmd), int'(bus_shared), int'(bus_flush),
                             int'(bus_addr), int'(bus_data));
      log_n = log_n + 1;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NL; i++) begin
        mst[c][i] = 0; mtg[c][i] = 0; mdt[c][i] = 0;
      end
    for (int a = 0; a < NA; a++) begin
      mem[a]  = (a * 32 + a * 4 + a + 11) & 255;
      mval[a] = mem[a];
    end
  endtask

  task automatic predict(int c, bit wr, int a, int wd);
    int ix, tg, sh, fl, dv;
    ix = a % NL;
    tg = a / NL;
    exp_n = 0;
    if (mst[c][ix] == 3 && mtg[c][ix] != tg) begin
      exp_pk[exp_n++] = pack(3, 0, 0, mtg[c][ix] * NL + ix, mdt[c][ix]);
      mem[mtg[c][ix] * NL + ix] = mdt[c][ix];
      mst[c][ix] = 0;
    end
    if (mst[c][ix] == 0 || mtg[c][ix] != tg) begin
      sh = 0; fl = 0; dv = mem[a];
      for (int d = 0; d < NC; d++) begin
        if (d != c && mst[d][ix] != 0 && mtg[d][ix] == tg) begin
          sh = 1;
          if (mst[d][ix] == 3) begin
            fl = 1; dv = mdt[d][ix]; mem[a] = dv;
          end
          mst[d][ix] = wr ? 0 : 1;
        end
      end
      exp_pk[exp_n++] = pack(wr ? 1 : 0, sh, fl, a, dv);
      mtg[c][ix] = tg;
      mdt[c][ix] = dv;
      mst[c][ix] = wr ? 3 : (sh ? 1 : 2);
    end else if (wr && mst[c][ix] == 1) begin
      sh = 0;
      for (int d = 0; d < NC; d++) begin
        if (d != c && mst[d][ix] != 0 && mtg[d][ix] == tg) begin
          sh = 1; mst[d][ix] = 0;
        end
      end
      exp_pk[exp_n++] = pack(2, sh, 0, a, 0);
    end
    if (wr) begin
      mdt[c][ix] = wd; mst[c][ix] = 3; mval[a] = wd;
    end else begin
      exp_rd = mdt[c][ix];
    end
  endtask

  task automatic do_op(int c, bit wr, int a, int wd, string tag);
    bit got;
    int rd;
    predict(c, wr, a, wd);
    @(negedge clk);
    log_n = 0;
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW]  = AW'(a);
    req_wdata[c*DW +: DW] = DW'(wd);
    got = 0;
    rd  = 0;
    for (int t = 0; t < 60 && !got; t++) begin
      @(negedge clk); #1;
      if (req_done[c]) begin
        got = 1;
        rd  = int'(req_rdata[c*DW +: DW]);
      end
    end
    req_valid[c] = 1'b0;
    chk(got, tag, "request completion", int'(got), 1);
    @(negedge clk); #1;
    chk(req_done[c] == 1'b0, "R11", "single done pulse", int'(req_done[c]), 0);
    chk(log_n == exp_n, tag, "bus transaction count", log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++)
      chk(log_pk[k] == exp_pk[k], tag, "bus transaction", log_pk[k], exp_pk[k]);
    if (!wr) begin
      chk(rd == exp_rd, tag, "load word", rd, exp_rd);
      chk(rd == mval[a], "R13", "last stored value", rd, mval[a]);
    end
  endtask

  initial begin
    #(150000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    bit got [NC];
    int rdv [NC];
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_done == '0, "R1", "no done after reset", int'(req_done), 0);
    chk(bus_valid == 1'b0, "R1", "idle bus after reset", int'(bus_valid), 0);

    do_op(0, 0, 5, 0, "R2");      // exclusive fill from memory
    do_op(0, 1, 5, 'hA1, "R4");   // silent store to Exclusive
    do_op(1, 0, 5, 0, "R7");      // Modified owner supplies, both Shared
    do_op(1, 1, 5, 'hB2, "R6");   // upgrade from Shared
    do_op(2, 1, 5, 'hC3, "R8");   // ownership request takes word from owner
    do_op(2, 0, 9, 0, "R10");     // dirty victim written back before fill
    do_op(2, 0, 9, 0, "R11");     // load hit, no bus traffic
    do_op(0, 0, 9, 0, "R3");      // Shared fill, holder downgraded
    do_op(2, 1, 9, 'h5D, "R5");   // downgraded holder must upgrade
    do_op(1, 1, 2, 'h77, "R9");   // store miss
    do_op(1, 1, 2, 'h78, "R4");   // store to Modified stays local
    do_op(0, 0, 2, 0, "R7");

    lf = 16'hACE1;
    for (int n = 0; n < 900; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_op(int'(lf[1:0]) % NC, lf[4], int'(lf[11:8]), int'(lf[15:8] ^ lf[7:0]), "R13");
    end

    // R12: all cores request the same line at once
    do_op(0, 1, 6, 'h3C, "R9");
    @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      got[k] = 0; rdv[k] = 0;
      req_valid[k] = 1'b1;
      req_write[k] = 1'b0;
      req_addr[k*AW +: AW] = AW'(6);
    end
    for (int t = 0; t < 80; t++) begin
      @(negedge clk); #1;
      for (int k = 0; k < NC; k++) begin
        if (req_done[k] && !got[k]) begin
          got[k] = 1;
          rdv[k] = int'(req_rdata[k*DW +: DW]);
          req_valid[k] = 1'b0;
        end
      end
    end
    for (int k = 0; k < NC; k++) begin
      chk(got[k], "R12", "concurrent completion", int'(got[k]), 1);
      chk(rdv[k] == mval[6], "R12", "concurrent load word", rdv[k], mval[6]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule